// File: doc/BRIEF.md
# Serial Interrupt Identification Arbiter

This block decides which of five interrupt conditions a register-compatible serial controller reports, and which code the identification register shows for it. The controller around it supplies the status conditions as plain levels and pulses: the line error flags, data-ready, a character-timeout flag, the receive FIFO fill count and its trigger level, the modem delta flags, and events from the transmit path. The block holds the 4-bit interrupt enable register and the transmit-empty pending flag. Every cycle it registers the identification byte and a level interrupt line.

A bus decoder drives three things into the block: a write strobe for the enable register, a read strobe for the identification register, and the FIFO-enable level. Reading the identification register while it shows the transmit-empty code retires that condition. Writing the enable register while the holding register is empty re-arms it. The FIFO storage, the serializer, the baud generator and the bus decoder itself are outside the block.

Top module: `sirq_id_arbiter`

## Requirements
- R1: After reset the identification byte reads 0x01, the interrupt line is low and the enable readback is 0x00.
- R2: The low nibble of the identification byte is one of these codes: 0x6 line status, 0xC character timeout, 0x4 received data, 0x2 transmit empty, 0x0 modem status, 0x1 nothing pending.
- R3: When several sources are active, the code reported is the first active one in this order: line status, timeout, received data, transmit empty, modem status.
- R4: Line status is active when enable bit 2 is set and any of the four `line_err` bits is set.
- R5: Character timeout is active when `rx_timeout` is high and enable bit 0 is set. No other enable bit gates it.
- R6: Received data is active when enable bit 0 and `data_ready` are set, and either `fifo_en` is low or `rx_count` is greater than or equal to `rx_trig`.
- R7: Transmit empty is active when enable bit 1 and the pending flag are both set. A `thr_done` pulse sets the pending flag and a `thr_load` pulse clears it.
- R8: A read (`id_rd`) while the registered code is 0x2 clears the pending flag. A read while any other code is shown leaves the flag unchanged.
- R9: An enable write while `thr_empty` is high sets the pending flag.
- R10: Bits 7:4 of the identification byte are 0xC in the cycle after `fifo_en` was high, and 0x0 otherwise.
- R11: The interrupt line is high exactly when the registered code is not 0x1. Both outputs show the state of the previous cycle, so an input change appears one clock later.
- R12: The enable register keeps only bits 3:0 of a write. Bits 7:4 of the readback are zero.
- R13: Modem status is active when enable bit 3 is set and any `msr_delta` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| id_rd | input | 1 | Identification register read strobe |
| fifo_en | input | 1 | FIFOs enabled |
| line_err | input | 4 | Overrun, parity, framing and break flags |
| data_ready | input | 1 | Receive data present |
| rx_timeout | input | 1 | Character timeout pending |
| rx_count | input | 5 | Receive FIFO fill count |
| rx_trig | input | 5 | Receive trigger level |
| thr_done | input | 1 | Pulse: holding register went empty |
| thr_load | input | 1 | Pulse: holding register written |
| thr_empty | input | 1 | Holding register empty level |
| msr_delta | input | 4 | Modem status delta flags |
| en_rdata | output | 8 | Enable register readback |
| id_value | output | 8 | Identification byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench aims at the trigger-level boundary, with the count one below the trigger and then equal to it. A comparison off by one there would raise received-data one character early or late. It also reads the identification register under two different codes. If the clear were keyed on the read alone, the transmit-empty condition would be lost behind a timeout. If the clear were missing, the interrupt would never fall. Further cases check that the timeout stays masked when only the transmit enable is set, that an enable write re-arms a retired transmit-empty condition, and that the FIFO flag nibble follows `fifo_en` with one cycle of delay.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int NSRC = 5;

  localparam logic [3:0] CODE_MODEM  = 4'h0;
  localparam logic [3:0] CODE_NONE   = 4'h1;
  localparam logic [3:0] CODE_THRE   = 4'h2;
  localparam logic [3:0] CODE_RXDATA = 4'h4;
  localparam logic [3:0] CODE_LINE   = 4'h6;
  localparam logic [3:0] CODE_TMO    = 4'hC;
  localparam logic [3:0] FIFO_FLAGS  = 4'hC;

  // rank 0 is the highest priority
  function automatic logic [3:0] rank_code(input int rank);
    case (rank)
      0:       rank_code = CODE_LINE;
      1:       rank_code = CODE_TMO;
      2:       rank_code = CODE_RXDATA;
      3:       rank_code = CODE_THRE;
      default: rank_code = CODE_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/sirq_rst_sync.sv
module sirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/sirq_enable_reg.sv
module sirq_enable_reg #(
  parameter int EN_W  = 4,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [EN_W-1:0]  wdata,
  output logic [EN_W-1:0]  en_q,
  output logic [BUS_W-1:0] rdata
);
  logic [EN_W-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (wr) en_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign rdata = {{(BUS_W-EN_W){1'b0}}, en_q};
endmodule

// File: rtl/sirq_thr_pend.sv
module sirq_thr_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic load,
  input  logic rearm,
  input  logic rd_clear,
  output logic pend_q
);
  logic pend_d;

  // later assignments win: setting events override clears
  always_comb begin
    pend_d = pend_q;
    if (rd_clear) pend_d = 1'b0;
    if (load)     pend_d = 1'b0;
    if (set_evt)  pend_d = 1'b1;
    if (rearm)    pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/sirq_prio.sv
module sirq_prio
  import sirq_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int ERR_W   = 4,
  parameter int DELTA_W = 4
) (
  input  logic [3:0]         en,
  input  logic [ERR_W-1:0]   line_err,
  input  logic               data_ready,
  input  logic               rx_timeout,
  input  logic               fifo_en,
  input  logic [CNT_W-1:0]   rx_count,
  input  logic [CNT_W-1:0]   rx_trig,
  input  logic               thr_pend,
  input  logic [DELTA_W-1:0] msr_delta,
  output logic [3:0]         code
);
  logic [NSRC-1:0] req;
  logic            at_trigger;

  assign at_trigger = (rx_count >= rx_trig);

  assign req[0] = en[2] & (|line_err);
  assign req[1] = en[0] & rx_timeout;
  assign req[2] = en[0] & data_ready & (~fifo_en | at_trigger);
  assign req[3] = en[1] & thr_pend;
  assign req[4] = en[3] & (|msr_delta);

  always_comb begin
    code = CODE_NONE;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (req[i]) code = rank_code(i);
    end
  end
endmodule

// File: rtl/sirq_id_arbiter.sv
module sirq_id_arbiter
  import sirq_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int CNT_W   = 5,
  parameter int ERR_W   = 4,
  parameter int DELTA_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr,
  input  logic [BUS_W-1:0]   en_wdata,
  input  logic               id_rd,
  input  logic               fifo_en,
  input  logic [ERR_W-1:0]   line_err,
  input  logic               data_ready,
  input  logic               rx_timeout,
  input  logic [CNT_W-1:0]   rx_count,
  input  logic [CNT_W-1:0]   rx_trig,
  input  logic               thr_done,
  input  logic               thr_load,
  input  logic               thr_empty,
  input  logic [DELTA_W-1:0] msr_delta,
  output logic [BUS_W-1:0]   en_rdata,
  output logic [BUS_W-1:0]   id_value,
  output logic               irq
);
  localparam int EN_W = 4;

  logic             rst_ns;
  logic [EN_W-1:0]  en_q;
  logic             thr_pend;
  logic             rd_clear;
  logic [3:0]       code;
  logic [BUS_W-1:0] id_q, id_d;
  logic             irq_q, irq_d;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^en_wdata[BUS_W-1:EN_W];

  sirq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_ni(rst_n), .rst_no(rst_ns)
  );

  sirq_enable_reg #(.EN_W(EN_W), .BUS_W(BUS_W)) u_en (
    .clk(clk), .rst_n(rst_ns), .wr(en_wr), .wdata(en_wdata[EN_W-1:0]),
    .en_q(en_q), .rdata(en_rdata)
  );

  assign rd_clear = id_rd & (id_q[3:0] == CODE_THRE);

  sirq_thr_pend u_pend (
    .clk(clk), .rst_n(rst_ns), .set_evt(thr_done), .load(thr_load),
    .rearm(en_wr & thr_empty), .rd_clear(rd_clear), .pend_q(thr_pend)
  );

  sirq_prio #(.CNT_W(CNT_W), .ERR_W(ERR_W), .DELTA_W(DELTA_W)) u_prio (
    .en(en_q), .line_err(line_err), .data_ready(data_ready),
    .rx_timeout(rx_timeout), .fifo_en(fifo_en), .rx_count(rx_count),
    .rx_trig(rx_trig), .thr_pend(thr_pend), .msr_delta(msr_delta),
    .code(code)
  );

  always_comb begin
    id_d = '0;
    id_d[3:0] = code;
    if (fifo_en) id_d[7:4] = FIFO_FLAGS;
    irq_d = (code != CODE_NONE);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      id_q  <= {{(BUS_W-4){1'b0}}, CODE_NONE};
      irq_q <= 1'b0;
    end else begin
      id_q  <= id_d;
      irq_q <= irq_d;
    end
  end

  assign id_value = id_q;
  assign irq      = irq_q;
endmodule

// File: rtl/sirq_id_checker.sv
module sirq_id_checker (
  input logic       clk,
  input logic       rst_ns,
  input logic       id_rd,
  input logic       fifo_en,
  input logic [3:0] line_err,
  input logic       en_wr,
  input logic       thr_empty,
  input logic       thr_done,
  input logic [3:0] en_q,
  input logic       thr_pend,
  input logic [7:0] en_rdata,
  input logic [7:0] id_value,
  input logic       irq
);
  assert_irq_level_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    irq == (id_value[3:0] != 4'h1));

  assert_upper_zero_R12: assert property (@(posedge clk) disable iff (!rst_ns)
    en_rdata[7:4] == 4'h0);

  assert_fifo_nibble_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    fifo_en |=> id_value[7:4] == 4'hC);

  assert_line_wins_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    (en_q[2] && |line_err) |=> id_value[3:0] == 4'h6);

  assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (en_wr && thr_empty) |=> thr_pend);

  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (id_rd && id_value[3:0] == 4'h2 && !thr_done && !(en_wr && thr_empty))
      |=> !thr_pend);

  assert_code_set_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    id_value[3:0] inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h6, 4'hC});
endmodule

bind sirq_id_arbiter sirq_id_checker u_chk (
  .clk(clk), .rst_ns(rst_ns), .id_rd(id_rd), .fifo_en(fifo_en),
  .line_err(line_err), .en_wr(en_wr), .thr_empty(thr_empty),
  .thr_done(thr_done), .en_q(en_q), .thr_pend(thr_pend),
  .en_rdata(en_rdata), .id_value(id_value), .irq(irq)
);

// File: tb/sirq_id_arbiter_bench.sv
module sirq_id_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_wr, id_rd, fifo_en, data_ready, rx_timeout;
  logic       thr_done, thr_load, thr_empty;
  logic [7:0] en_wdata;
  logic [3:0] line_err, msr_delta;
  logic [4:0] rx_count, rx_trig;
  logic [7:0] en_rdata, id_value;
  logic       irq;

  int checks = 0;
  int errors = 0;

  // reference model state
  int  m_en, m_pend, m_id, m_irq;

  always #10 clk = ~clk;

  sirq_id_arbiter u_sirq_id_arbiter (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .id_rd(id_rd), .fifo_en(fifo_en), .line_err(line_err),
    .data_ready(data_ready), .rx_timeout(rx_timeout), .rx_count(rx_count),
    .rx_trig(rx_trig), .thr_done(thr_done), .thr_load(thr_load),
    .thr_empty(thr_empty), .msr_delta(msr_delta), .en_rdata(en_rdata),
    .id_value(id_value), .irq(irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic int model_code();
    int en = m_en;
    if ((en & 4) != 0 && line_err != 0)            return 'h6;
    if ((en & 1) != 0 && rx_timeout)               return 'hC;
    if ((en & 1) != 0 && data_ready &&
        (!fifo_en || int'(rx_count) >= int'(rx_trig))) return 'h4;
    if ((en & 2) != 0 && m_pend != 0)              return 'h2;
    if ((en & 8) != 0 && msr_delta != 0)           return 'h0;
    return 'h1;
  endfunction

  // one clock: model update at the edge, compare at the falling edge
  task automatic tick();
    int c;
    int np;
    @(posedge clk);
    c  = model_code();
    np = m_pend;
    if (id_rd && (m_id % 16) == 2) np = 0;
    if (thr_load) np = 0;
    if (thr_done) np = 1;
    if (en_wr && thr_empty) np = 1;
    m_pend = np;
    if (en_wr) m_en = en_wdata % 16;
    m_id  = (fifo_en ? 'hC0 : 0) + c;
    m_irq = (c != 1) ? 1 : 0;
    @(negedge clk);
    chk("R2 id per-cycle", id_value, m_id);
    chk("R11 irq per-cycle", irq, m_irq);
    chk("R12 enable per-cycle", en_rdata, m_en);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    en_wr = 0; en_wdata = 0; id_rd = 0; fifo_en = 0; line_err = 0;
    data_ready = 0; rx_timeout = 0; rx_count = 0; rx_trig = 0;
    thr_done = 0; thr_load = 0; thr_empty = 0; msr_delta = 0;
    m_en = 0; m_pend = 0; m_id = 1; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ticks(4);
    chk("R1 reset id", id_value, 'h01);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset enable", en_rdata, 0);

    // R12: only low nibble kept
    en_wr = 1; en_wdata = 8'hFF; tick(); en_wr = 0; tick();
    chk("R12 enable readback", en_rdata, 'h0F);

    // R7: transmit-empty set by done pulse
    thr_empty = 1; thr_done = 1; tick(); thr_done = 0; tick();
    chk("R7 thr code", id_value, 'h02);
    chk("R11 irq high", irq, 1);

    // R10 and R3: fifo flags, thr beats modem
    fifo_en = 1; msr_delta = 4'b0100; ticks(2);
    chk("R10 fifo nibble", id_value, 'hC2);

    // R8 and R13: read retires thr, modem shows
    id_rd = 1; tick(); id_rd = 0; tick();
    chk("R8 read clears thr / R13 modem", id_value, 'hC0);

    // R6: trigger boundary
    msr_delta = 0; data_ready = 1; rx_trig = 5'd4; rx_count = 5'd3; ticks(2);
    chk("R6 below trigger", id_value, 'hC1);
    chk("R11 irq low", irq, 0);
    rx_count = 5'd4; ticks(2);
    chk("R6 at trigger", id_value, 'hC4);
    fifo_en = 0; rx_count = 0; ticks(2);
    chk("R6 fifo off", id_value, 'h04);

    // R5 timeout, R4 line status
    rx_timeout = 1; ticks(2);
    chk("R5 timeout", id_value, 'h0C);
    line_err = 4'b0010; ticks(2);
    chk("R4 line status", id_value, 'h06);

    // R9 rearm by enable write; line masked
    en_wr = 1; en_wdata = 8'h0B; tick(); en_wr = 0; tick();
    chk("R3 timeout when line masked", id_value, 'h0C);
    id_rd = 1; tick(); id_rd = 0; tick();
    rx_timeout = 0; data_ready = 0; line_err = 0; ticks(2);
    chk("R9 rearm / R8 read under other code keeps flag", id_value, 'h02);

    // R5 masked without bit 0
    en_wr = 1; en_wdata = 8'h02; tick(); en_wr = 0; rx_timeout = 1; ticks(2);
    chk("R5 timeout masked", id_value, 'h02);
    id_rd = 1; tick(); id_rd = 0; tick();
    chk("R8 cleared to none", id_value, 'h01);
    rx_timeout = 0;

    // R7 load clears pending
    thr_done = 1; tick(); thr_done = 0; thr_load = 1; tick(); thr_load = 0; ticks(2);
    chk("R7 load clears", id_value, 'h01);
    chk("R7 irq low", irq, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule